// File: doc/BRIEF.md
# Infrared Remote Frame Envelope Generator

This block turns a key press into the on/off envelope of a pulse-distance infrared remote frame. The envelope is meant to gate an external carrier oscillator of about 38 kHz. A single start strobe, given while the block is idle, captures an 8-bit address code and an 8-bit command code. The block then emits a long leader mark, a leader space, 32 data bits, and a closing short mark. Each data bit is a short mark followed by a space whose length tells a one from a zero.

While the key-held input stays high, the block keeps a fixed frame-to-frame period. In each later period it sends a short repeat burst instead of the full frame: a long mark, a short space and the closing mark. All durations are counted on a tick-enable input with a nominal period of 1/32 ms. The tick counts are parameters, so the block also works with a faster timebase. A busy flag covers the whole sequence, including the silent gaps between frames.

Top module: `ir_frame_encoder`

## Requirements
- R1: After reset, and right after any reset asserted mid-frame, `env_out` is 0 and `busy` is 0.
- R2: A frame starts with a mark of TICK_LEAD_MARK ticks (288). A space of TICK_LEAD_SPACE ticks (144) follows, and the envelope rises in the cycle after the accepted start strobe.
- R3: Every data bit is a mark of TICK_BIT_MARK ticks (18). The space that follows is TICK_ZERO_SPACE ticks (18) for a 0 and TICK_ONE_SPACE ticks (54) for a 1.
- R4: The 32 bits go out least significant bit first, as four bytes in this order: address, inverted address, command, inverted command. A closing mark of TICK_STOP_MARK ticks (18) follows them.
- R5: A start strobe that arrives while `busy` is high has no effect. Codes are sampled only when a start strobe is accepted, so changing them mid-frame has no effect on the frame in progress.
- R6: If `key_held` is low when the closing mark ends, `busy` and `env_out` both fall at that point. With the default ticks, a full frame then lasts 2178 ticks.
- R7: While `key_held` stays high, a new burst begins every TICK_PERIOD ticks (3456) from the previous frame start. Each later burst is a repeat: a mark of 288 ticks, a space of TICK_RPT_SPACE ticks (72) and a closing mark of 18 ticks.
- R8: If `key_held` is low when a period ends, no further burst is sent and `busy` falls on that period boundary.
- R9: Durations advance only on cycles where `tick` is 1. With `tick` high once every N cycles, every segment stretches by a factor of N.
- R10: Whenever `busy` is 0, `env_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one pulse per time unit |
| start | input | 1 | Begin a frame when idle |
| key_held | input | 1 | High while the key remains pressed |
| custom_code | input | CODE_W | Address byte, sampled on an accepted start |
| data_code | input | CODE_W | Command byte, sampled on an accepted start |
| env_out | output | 1 | Carrier gate: 1 during marks |
| busy | output | 1 | High from an accepted start until the sequence ends |

## Verification
Address and command patterns with very different bit content are sent. A design that swapped the bit order, left out an inversion or mixed up the one/zero spaces would show a wrong run-length list. A start strobe together with new codes is injected mid-frame; a design that re-armed or sampled codes late would change or restart the frame. The key is released once during a repeat burst and once during the gap. A design that decided at the wrong point would send an extra repeat or cut the gap short, and a sparse timebase shows any segment that counts clocks instead of ticks.

// File: rtl/ir_enc_pkg.sv
package ir_enc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD_MARK,
        ST_LEAD_SPACE,
        ST_BIT_MARK,
        ST_BIT_SPACE,
        ST_STOP_MARK,
        ST_GAP,
        ST_RPT_MARK,
        ST_RPT_SPACE
    } ir_state_e;

    // Envelope is driven high only in the mark segments
    function automatic logic is_mark(ir_state_e s);
        return (s == ST_LEAD_MARK) || (s == ST_BIT_MARK) ||
               (s == ST_STOP_MARK) || (s == ST_RPT_MARK);
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ir_seg_timer.sv
// Down-counter for one envelope segment, advanced by the tick enable
module ir_seg_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } seg_t;

    seg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt = load_val;
        end else if (tick && (r_q.cnt != '0)) begin
            r_d.cnt = r_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done = tick && (r_q.cnt == W'(1));
endmodule

// File: rtl/ir_period_timer.sv
// Counts ticks since the last burst start; flags the repeat boundary
module ir_period_timer #(
    parameter int PERIOD = 3456,
    localparam int PW    = $clog2(PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    input  logic run,
    output logic wrap
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } per_t;

    per_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.cnt = '0;
        end else if (run && tick) begin
            r_d.cnt = wrap ? '0 : r_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wrap = run && tick && (r_q.cnt == PW'(PERIOD - 1));
endmodule

// File: rtl/ir_bit_shifter.sv
// Holds the 32-bit payload and presents it one bit at a time, LSB first
module ir_bit_shifter #(
    parameter int NBITS  = 32,
    localparam int CW    = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] word_in,
    input  logic             shift,
    output logic             cur_bit,
    output logic             last
);
    typedef struct packed {
        logic [NBITS-1:0] word;
        logic [CW-1:0]    left;
    } sh_t;

    sh_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.word = word_in;
            r_d.left = CW'(NBITS);
        end else if (shift) begin
            r_d.word = {1'b0, r_q.word[NBITS-1:1]};
            r_d.left = r_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cur_bit = r_q.word[0];
    assign last    = (r_q.left == CW'(1));
endmodule

// File: rtl/ir_frame_encoder.sv
module ir_frame_encoder
    import ir_enc_pkg::*;
#(
    parameter int CODE_W          = 8,
    parameter int TICK_LEAD_MARK  = 288,
    parameter int TICK_LEAD_SPACE = 144,
    parameter int TICK_RPT_SPACE  = 72,
    parameter int TICK_BIT_MARK   = 18,
    parameter int TICK_ZERO_SPACE = 18,
    parameter int TICK_ONE_SPACE  = 54,
    parameter int TICK_STOP_MARK  = 18,
    parameter int TICK_PERIOD     = 3456
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              key_held,
    input  logic [CODE_W-1:0] custom_code,
    input  logic [CODE_W-1:0] data_code,
    output logic              env_out,
    output logic              busy
);
    localparam int FRAME_BITS = 4 * CODE_W;
    localparam int SEG_MAX    = max_of(max_of(max_of(TICK_LEAD_MARK, TICK_LEAD_SPACE),
                                              max_of(TICK_RPT_SPACE, TICK_BIT_MARK)),
                                       max_of(max_of(TICK_ZERO_SPACE, TICK_ONE_SPACE),
                                              TICK_STOP_MARK));
    localparam int SEG_W      = $clog2(SEG_MAX + 1);

    typedef struct packed {
        ir_state_e state;
        logic      env;
        logic      busy;
    } ctl_t;

    ctl_t r_q, r_d;

    logic             seg_load;
    logic [SEG_W-1:0] seg_val;
    logic             seg_done;
    logic             sh_load;
    logic             sh_shift;
    logic             cur_bit;
    logic             last_bit;
    logic             per_clear;
    logic             per_run;
    logic             per_wrap;
    logic [FRAME_BITS-1:0] frame_word;

    // Byte order on air: address, ~address, command, ~command
    assign frame_word = {~data_code, data_code, ~custom_code, custom_code};
    assign per_run    = (r_q.state != ST_IDLE);

    ir_seg_timer #(.W(SEG_W)) u_seg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (seg_load),
        .load_val (seg_val),
        .done     (seg_done)
    );

    ir_period_timer #(.PERIOD(TICK_PERIOD)) u_per (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clear (per_clear),
        .run   (per_run),
        .wrap  (per_wrap)
    );

    ir_bit_shifter #(.NBITS(FRAME_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .word_in (frame_word),
        .shift   (sh_shift),
        .cur_bit (cur_bit),
        .last    (last_bit)
    );

    always_comb begin
        r_d       = r_q;
        seg_load  = 1'b0;
        seg_val   = '0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        per_clear = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_LEAD_MARK;
                    seg_load  = 1'b1;
                    seg_val   = SEG_W'(TICK_LEAD_MARK);
                    sh_load   = 1'b1;
                    per_clear = 1'b1;
                end
            end
            ST_LEAD_MARK: begin
                if (seg_done) begin
                    r_d.state = ST_LEAD_SPACE;
                    seg_load  = 1'b1;
                    seg_val   = SEG_W'(TICK_LEAD_SPACE);
                end
            end
            ST_LEAD_SPACE: begin
                if (seg_done) begin
                    r_d.state = ST_BIT_MARK;
                    seg_load  = 1'b1;
                    seg_val   = SEG_W'(TICK_BIT_MARK);
                end
            end
            ST_BIT_MARK: begin
                if (seg_done) begin
                    r_d.state = ST_BIT_SPACE;
                    seg_load  = 1'b1;
                    seg_val   = cur_bit ? SEG_W'(TICK_ONE_SPACE) : SEG_W'(TICK_ZERO_SPACE);
                end
            end
            ST_BIT_SPACE: begin
                if (seg_done) begin
                    sh_shift = 1'b1;
                    seg_load = 1'b1;
                    if (last_bit) begin
                        r_d.state = ST_STOP_MARK;
                        seg_val   = SEG_W'(TICK_STOP_MARK);
                    end else begin
                        r_d.state = ST_BIT_MARK;
                        seg_val   = SEG_W'(TICK_BIT_MARK);
                    end
                end
            end
            ST_STOP_MARK: begin
                if (seg_done) begin
                    r_d.state = key_held ? ST_GAP : ST_IDLE;
                end
            end
            ST_GAP: begin
                if (per_wrap) begin
                    if (key_held) begin
                        r_d.state = ST_RPT_MARK;
                        seg_load  = 1'b1;
                        seg_val   = SEG_W'(TICK_LEAD_MARK);
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_RPT_MARK: begin
                if (seg_done) begin
                    r_d.state = ST_RPT_SPACE;
                    seg_load  = 1'b1;
                    seg_val   = SEG_W'(TICK_RPT_SPACE);
                end
            end
            ST_RPT_SPACE: begin
                if (seg_done) begin
                    r_d.state = ST_STOP_MARK;
                    seg_load  = 1'b1;
                    seg_val   = SEG_W'(TICK_STOP_MARK);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        r_d.env  = is_mark(r_d.state);
        r_d.busy = (r_d.state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.env   <= 1'b0;
            r_q.busy  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign env_out = r_q.env;
    assign busy    = r_q.busy;
endmodule

// File: rtl/ir_frame_encoder_chk.sv
module ir_frame_encoder_chk #(
    parameter int LONG_TICKS  = 288,
    parameter int SHORT_TICKS = 18,
    parameter int STOP_TICKS  = 18
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic start,
    input logic env_out,
    input logic busy
);
    int mark_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mark_ticks <= 0;
        else if (env_out) mark_ticks <= mark_ticks + (tick ? 1 : 0);
        else              mark_ticks <= 0;
    end

    // Envelope stays low while the block is idle (R10)
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !env_out);

    // A sequence opens only after a start strobe, and opens with a mark (R2)
    p_open_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (env_out && $past(start)));

    // No tick, no progress while a sequence runs (R9)
    p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> (busy && $stable(env_out)));

    // Every mark lasts one of the legal tick counts (R3)
    p_mark_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(env_out) |-> ((mark_ticks == SHORT_TICKS) || (mark_ticks == STOP_TICKS) ||
                            (mark_ticks == LONG_TICKS)));

    // A start while busy does not re-open the leader mark (R5)
    p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !env_out && !tick) |=> !env_out);
endmodule

bind ir_frame_encoder ir_frame_encoder_chk #(
    .LONG_TICKS  (TICK_LEAD_MARK),
    .SHORT_TICKS (TICK_BIT_MARK),
    .STOP_TICKS  (TICK_STOP_MARK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start   (start),
    .env_out (env_out),
    .busy    (busy)
);

// File: tb/ir_frame_encoder_bench.sv
module ir_frame_encoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       start = 1'b0;
    logic       key_held = 1'b0;
    logic [7:0] cust = 8'h00;
    logic [7:0] data = 8'h00;
    logic       env_out;
    logic       busy;

    always #4 clk = ~clk;

    ir_frame_encoder u_ir_frame_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start       (start),
        .key_held    (key_held),
        .custom_code (cust),
        .data_code   (data),
        .env_out     (env_out),
        .busy        (busy)
    );

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    int got_lvl [0:255];
    int got_len [0:255];
    int got_n;
    int exp_lvl [0:255];
    int exp_len [0:255];
    int exp_n;
    int busy_cycles;

    // {address, command, expected frame length in ticks}
    localparam logic [31:0] VEC [0:3] = '{
        {8'h00, 8'hFF, 16'd2178},
        {8'hA5, 8'h3C, 16'd2178},
        {8'h01, 8'h80, 16'd2178},
        {8'hFF, 8'h00, 16'd2178}
    };

    initial begin : tick_gen
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = ph + 1;
            tick = ((ph % tick_div) == 0);
        end
    end

    initial begin : watchdog
        #(8 * 190000);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic add_run(input int lvl, input int len);
        exp_lvl[exp_n] = lvl;
        exp_len[exp_n] = len;
        exp_n = exp_n + 1;
    endtask

    task automatic build_frame(input logic [7:0] c, input logic [7:0] d);
        logic [31:0] w;
        exp_n = 0;
        w = {~d, d, ~c, c};
        add_run(1, 288);
        add_run(0, 144);
        for (int i = 0; i < 32; i++) begin
            add_run(1, 18);
            add_run(0, w[i] ? 54 : 18);
        end
        add_run(1, 18);
    endtask

    task automatic compare_runs(input string req);
        int bad;
        bad = -1;
        chk(got_n == exp_n, req, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (bad < 0 && (got_lvl[i] != exp_lvl[i] || got_len[i] != exp_len[i])) bad = i;
        end
        if (bad >= 0) chk(1'b0, req, got_len[bad], exp_len[bad]);
        else          chk(1'b1, req, 0, 0);
    endtask

    // Starts a sequence and records envelope run lengths until busy drops
    task automatic capture(input int release_at, input int restart_at,
                           input logic [7:0] alt_c, input logic [7:0] alt_d);
        int cyc;
        int lvl;
        int len;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_n = 0;
        cyc = 0;
        lvl = int'(env_out);
        len = 0;
        while (busy && cyc < 60000) begin
            if (int'(env_out) != lvl) begin
                got_lvl[got_n] = lvl;
                got_len[got_n] = len;
                got_n = got_n + 1;
                lvl = int'(env_out);
                len = 0;
            end
            len = len + 1;
            cyc = cyc + 1;
            if (cyc == release_at) key_held = 1'b0;
            if (cyc == restart_at) begin
                start = 1'b1;
                cust = alt_c;
                data = alt_d;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        got_lvl[got_n] = lvl;
        got_len[got_n] = len;
        got_n = got_n + 1;
        busy_cycles = cyc;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(env_out == 1'b0, "R1 env after reset", int'(env_out), 0);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: R2, R3, R4 via run lengths; R6 via total length
        for (int v = 0; v < 4; v++) begin
            cust = VEC[v][31:24];
            data = VEC[v][23:16];
            key_held = 1'b0;
            build_frame(VEC[v][31:24], VEC[v][23:16]);
            capture(-1, -1, 8'h00, 8'h00);
            compare_runs("R2 R3 R4 frame runs");
            chk(busy_cycles == int'(VEC[v][15:0]), "R6 frame length", busy_cycles,
                int'(VEC[v][15:0]));
            chk(env_out == 1'b0, "R10 env idle after frame", int'(env_out), 0);
            repeat (5) @(negedge clk);
        end

        // R5: start and new codes during a frame are ignored
        cust = 8'h5A;
        data = 8'hC3;
        build_frame(8'h5A, 8'hC3);
        capture(-1, 1000, 8'h0F, 8'h11);
        compare_runs("R5 mid-frame start ignored");
        chk(busy_cycles == 2178, "R5 frame not restarted", busy_cycles, 2178);
        repeat (5) @(negedge clk);

        // R7: key held, one repeat burst, released during the repeat mark
        cust = 8'h12;
        data = 8'h34;
        key_held = 1'b1;
        build_frame(8'h12, 8'h34);
        add_run(0, 3456 - 2178);
        add_run(1, 288);
        add_run(0, 72);
        add_run(1, 18);
        capture(3500, -1, 8'h00, 8'h00);
        compare_runs("R7 repeat burst runs");
        chk(busy_cycles == 3456 + 378, "R7 repeat end", busy_cycles, 3456 + 378);
        repeat (5) @(negedge clk);

        // R8: released during the gap after a repeat, nothing more is sent
        key_held = 1'b1;
        build_frame(8'h12, 8'h34);
        add_run(0, 3456 - 2178);
        add_run(1, 288);
        add_run(0, 72);
        add_run(1, 18);
        add_run(0, 3456 - 378);
        capture(3456 + 378 + 100, -1, 8'h00, 8'h00);
        compare_runs("R8 release in gap");
        chk(busy_cycles == 2 * 3456, "R8 ends on period boundary", busy_cycles, 2 * 3456);
        repeat (5) @(negedge clk);

        // R9: sparse timebase stretches every segment
        key_held = 1'b0;
        tick_div = 3;
        capture(-1, -1, 8'h00, 8'h00);
        chk(got_len[0] >= 3 * 288 - 2 && got_len[0] <= 3 * 288, "R9 stretched leader mark",
            got_len[0], 3 * 288);
        chk(got_n == 67, "R9 run count with sparse tick", got_n, 67);
        tick_div = 1;
        repeat (5) @(negedge clk);

        // R10: idle with no start keeps the envelope low
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 50; i++) begin
                if (env_out || busy) seen = seen + 1;
                @(negedge clk);
            end
            chk(seen == 0, "R10 idle quiet", seen, 0);
        end

        // R1: reset asserted mid-frame
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(env_out == 1'b0, "R1 env after mid-frame reset", int'(env_out), 0);
        chk(busy == 1'b0, "R1 busy after mid-frame reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule